// File: doc/BRIEF.md
# Status-Polled Flash Bank Erase-and-Program Sequencer

This block rewrites one bank of a byte-wide flash device whose commands are single bytes written to the array and whose progress shows up in a status byte. After a start pulse it erases the chosen bank and checks that the whole bank reads blank. It then programs the bank one byte at a time from a source buffer, and finally reads the bank back and compares it with the source. Every erase and every program step is followed by status polling. Polling ends when the device reports ready, or fails once a fixed number of polls has gone by.

The block drives a plain flash bus: an address, write data, a one-cycle write strobe and a one-cycle read strobe. Read data returns in the same cycle as the read strobe. The source buffer is addressed by a byte index, and its byte must be valid in the same cycle as that index. A completed run ends with a one-cycle done pulse. A two-bit result code and a sticky copy of the status fault bits stay valid until the next start.

Top module: `fbank_prog`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done, fl_we and fl_re are low and err_code is 0. A reset during a run abandons the run.
- R2: A start accepted while idle latches bank_sel. The next two bus cycles write 0x20 and then 0xD0 to the bank base, which is bank_sel times BANK_BYTES. No other bank is touched.
- R3: Each status poll is a write of 0x70 to the bank base followed in the next cycle by a read of the bank base. The device is ready when bit 7 of the byte read is 1.
- R4: Byte i is programmed by writing 0x40 to base+i, then waiting SETUP_WAIT idle cycles, then writing the source byte to base+i. The source byte is the one present on src_data while src_addr equals i. Bytes go in ascending order.
- R5: If POLL_LIMIT consecutive polls all read not ready, the run fails with err_code 1. Remaining bytes are not programmed and no verify read is made. A ready status on the last allowed poll is a success.
- R6: Every erase, every completed program sequence and every timeout is followed by a write of 0x50 and then a write of 0xFF to the bank base.
- R7: After an erase, every bank byte is read in ascending order. The first byte that is not 0xFF ends the run with err_code 2, and programming is skipped.
- R8: After programming, every bank byte is read back in ascending order and compared with the source. The first mismatch ends the run with err_code 3. A full match ends the run with err_code 0.
- R9: stat_err holds the OR of status bits 5 to 3 from every status read since the last start. It is reported even when err_code is 0.
- R10: done is high for exactly one cycle per run, with busy low in that cycle. busy is high from the cycle after start until done. A start while busy is ignored.
- R11: fl_we and fl_re are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a run (taken only while idle) |
| bank_sel | input | BANK_W | Bank to rewrite |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | 0 ok, 1 timeout, 2 blank check failed, 3 compare failed |
| stat_err | output | 3 | Sticky status bits 5..3 seen while polling |
| src_addr | output | OFS_W | Byte index into the source buffer |
| src_data | input | 8 | Source byte at src_addr, same cycle |
| fl_addr | output | BANK_W+OFS_W | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, valid with fl_re |

## Verification
A bad sequencer state shows up at the flash bus on the very next cycle. A command byte appears out of order, at the wrong address, or a poll write is not followed by a read, and the recorded write trace catches this no later than the end of the run. A poll counter that drifts by one makes a run end with a timeout one poll too early or too late, and the bench tests exactly this on the last allowed poll. A wrong byte index or a bad verify path only shows up at the end of the run, as a wrong err_code or as flash contents that differ from the source.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_E_ARM,
      S_E_GO,
      S_POLL_CMD,
      S_POLL_RD,
      S_CLR,
      S_RST,
      S_VERIFY,
      S_P_ARM,
      S_P_WAIT,
      S_P_DATA,
      S_DONE
   } fsm_t;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_TIMEOUT = 2'd1,
      ERR_BLANK   = 2'd2,
      ERR_COMPARE = 2'd3
   } fault_t;

   localparam logic [7:0] OP_ERASE_ARM = 8'h20;
   localparam logic [7:0] OP_ERASE_GO  = 8'hD0;
   localparam logic [7:0] OP_PROG_ARM  = 8'h40;
   localparam logic [7:0] OP_STATUS    = 8'h70;
   localparam logic [7:0] OP_CLR       = 8'h50;
   localparam logic [7:0] OP_ARRAY     = 8'hFF;
   localparam logic [7:0] ERASED_BYTE  = 8'hFF;

   localparam int READY_BIT = 7;
   localparam int FAULT_LSB = 3;
   localparam int FAULT_W   = 3;

endpackage

// File: rtl/fbp_limcnt.sv
module fbp_limcnt #(
   parameter  int LIMIT = 4,
   localparam int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] cnt,
   output logic          at_last
);

   if (LIMIT < 1) begin : g_bad_limit
      $error("fbp_limcnt: LIMIT must be at least 1");
   end

   if (LIMIT == 1) begin : g_unit
      logic unused_ctl;
      assign unused_ctl = clr | inc | clk | rst_n;
      assign cnt        = '0;
      assign at_last    = 1'b1;
   end else begin : g_count
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt <= '0;
         else if (clr)    cnt <= '0;
         else if (inc)    cnt <= at_last ? '0 : cnt + 1'b1;
      end
      assign at_last = (cnt == CW'(LIMIT - 1));

      assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= CW'(LIMIT - 1))
         else $error("counter above its limit");
   end

endmodule

// File: rtl/fbp_busdrv.sv
module fbp_busdrv
   import fbp_pkg::*;
#(
   parameter int BANK_W = 1,
   parameter int OFS_W  = 13
) (
   input  fsm_t                     state,
   input  logic [BANK_W-1:0]        bank,
   input  logic [OFS_W-1:0]         idx,
   input  logic [7:0]               src_byte,
   output logic [BANK_W+OFS_W-1:0]  addr,
   output logic [7:0]               wdata,
   output logic                     we,
   output logic                     re
);

   logic [BANK_W+OFS_W-1:0] base_addr;
   logic [BANK_W+OFS_W-1:0] byte_addr;

   assign base_addr = {bank, {OFS_W{1'b0}}};
   assign byte_addr = {bank, idx};

   always_comb begin
      addr  = base_addr;
      wdata = 8'h00;
      we    = 1'b0;
      re    = 1'b0;
      unique case (state)
         S_E_ARM:    begin we = 1'b1; wdata = OP_ERASE_ARM; end
         S_E_GO:     begin we = 1'b1; wdata = OP_ERASE_GO;  end
         S_POLL_CMD: begin we = 1'b1; wdata = OP_STATUS;    end
         S_POLL_RD:  begin re = 1'b1;                       end
         S_CLR:      begin we = 1'b1; wdata = OP_CLR;       end
         S_RST:      begin we = 1'b1; wdata = OP_ARRAY;     end
         S_VERIFY:   begin re = 1'b1; addr = byte_addr;     end
         S_P_ARM:    begin we = 1'b1; wdata = OP_PROG_ARM; addr = byte_addr; end
         S_P_DATA:   begin we = 1'b1; wdata = src_byte;    addr = byte_addr; end
         default:    ;
      endcase
   end

endmodule

// File: rtl/fbank_prog.sv
module fbank_prog
   import fbp_pkg::*;
#(
   parameter  int BANK_BYTES = 8192,
   parameter  int NUM_BANKS  = 2,
   parameter  int POLL_LIMIT = 1000000,
   parameter  int SETUP_WAIT = 50,
   localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int OFS_W      = $clog2(BANK_BYTES),
   localparam int ADDR_W     = BANK_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BANK_W-1:0] bank_sel,
   output logic              busy,
   output logic              done,
   output logic [1:0]        err_code,
   output logic [2:0]        stat_err,
   output logic [OFS_W-1:0]  src_addr,
   input  logic [7:0]        src_data,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [7:0]        fl_wdata,
   output logic              fl_we,
   output logic              fl_re,
   input  logic [7:0]        fl_rdata
);

   localparam int PCW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
   localparam int WCW = (SETUP_WAIT > 1) ? $clog2(SETUP_WAIT) : 1;

   if (BANK_BYTES < 2 || (BANK_BYTES & (BANK_BYTES - 1)) != 0) begin : g_bad_bank
      $error("fbank_prog: BANK_BYTES must be a power of two of at least 2");
   end
   if (NUM_BANKS < 1 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_count
      $error("fbank_prog: NUM_BANKS must be a power of two");
   end
   if (POLL_LIMIT < 1 || SETUP_WAIT < 1) begin : g_bad_timing
      $error("fbank_prog: POLL_LIMIT and SETUP_WAIT must be at least 1");
   end

   fsm_t              state_q, state_d;
   logic              prog_q, prog_d;
   logic              tmo_q, tmo_d;
   fault_t            fault_q, fault_d;
   logic [2:0]        sflag_q, sflag_d;
   logic [BANK_W-1:0] bank_q;

   logic              idx_clr, idx_inc, idx_last;
   logic [OFS_W-1:0]  idx;
   logic              poll_clr, poll_inc, poll_last;
   logic [PCW-1:0]    poll_cnt;
   logic              wait_clr, wait_inc, wait_last;
   logic [WCW-1:0]    wait_cnt;

   logic              ready;
   logic [7:0]        expect_byte;

   assign ready       = fl_rdata[READY_BIT];
   assign expect_byte = prog_q ? src_data : ERASED_BYTE;

   fbp_limcnt #(.LIMIT(BANK_BYTES)) u_idx (
      .clk(clk), .rst_n(rst_n), .clr(idx_clr), .inc(idx_inc),
      .cnt(idx), .at_last(idx_last));

   fbp_limcnt #(.LIMIT(POLL_LIMIT)) u_poll (
      .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc),
      .cnt(poll_cnt), .at_last(poll_last));

   fbp_limcnt #(.LIMIT(SETUP_WAIT)) u_wait (
      .clk(clk), .rst_n(rst_n), .clr(wait_clr), .inc(wait_inc),
      .cnt(wait_cnt), .at_last(wait_last));

   assign poll_clr = (state_q == S_E_GO) || (state_q == S_P_DATA);
   assign poll_inc = (state_q == S_POLL_RD) && !ready;
   assign wait_clr = (state_q == S_P_ARM);
   assign wait_inc = (state_q == S_P_WAIT);

   always_comb begin
      state_d = state_q;
      prog_d  = prog_q;
      tmo_d   = tmo_q;
      fault_d = fault_q;
      sflag_d = sflag_q;
      idx_clr = 1'b0;
      idx_inc = 1'b0;
      unique case (state_q)
         S_IDLE: begin
            if (start) begin
               state_d = S_E_ARM;
               prog_d  = 1'b0;
               tmo_d   = 1'b0;
               fault_d = ERR_NONE;
               sflag_d = '0;
               idx_clr = 1'b1;
            end
         end
         S_E_ARM:    state_d = S_E_GO;
         S_E_GO:     state_d = S_POLL_CMD;
         S_POLL_CMD: state_d = S_POLL_RD;
         S_POLL_RD: begin
            sflag_d = sflag_q | fl_rdata[FAULT_LSB +: FAULT_W];
            if (ready) begin
               if (prog_q && !idx_last) begin
                  idx_inc = 1'b1;
                  state_d = S_P_ARM;
               end else begin
                  state_d = S_CLR;
               end
            end else if (poll_last) begin
               tmo_d   = 1'b1;
               fault_d = ERR_TIMEOUT;
               state_d = S_CLR;
            end else begin
               state_d = S_POLL_CMD;
            end
         end
         S_CLR: state_d = S_RST;
         S_RST: begin
            if (tmo_q) begin
               state_d = S_DONE;
            end else begin
               idx_clr = 1'b1;
               state_d = S_VERIFY;
            end
         end
         S_VERIFY: begin
            if (fl_rdata != expect_byte) begin
               fault_d = prog_q ? ERR_COMPARE : ERR_BLANK;
               state_d = S_DONE;
            end else if (idx_last) begin
               if (prog_q) begin
                  state_d = S_DONE;
               end else begin
                  prog_d  = 1'b1;
                  idx_clr = 1'b1;
                  state_d = S_P_ARM;
               end
            end else begin
               idx_inc = 1'b1;
            end
         end
         S_P_ARM:  state_d = S_P_WAIT;
         S_P_WAIT: if (wait_last) state_d = S_P_DATA;
         S_P_DATA: state_d = S_POLL_CMD;
         S_DONE:   state_d = S_IDLE;
         default:  state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         prog_q  <= 1'b0;
         tmo_q   <= 1'b0;
         fault_q <= ERR_NONE;
         sflag_q <= '0;
         bank_q  <= '0;
      end else begin
         state_q <= state_d;
         prog_q  <= prog_d;
         tmo_q   <= tmo_d;
         fault_q <= fault_d;
         sflag_q <= sflag_d;
         if (state_q == S_IDLE && start) bank_q <= bank_sel;
      end
   end

   fbp_busdrv #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_bus (
      .state(state_q), .bank(bank_q), .idx(idx), .src_byte(src_data),
      .addr(fl_addr), .wdata(fl_wdata), .we(fl_we), .re(fl_re));

   assign busy     = (state_q != S_IDLE) && (state_q != S_DONE);
   assign done     = (state_q == S_DONE);
   assign err_code = fault_q;
   assign stat_err = sflag_q;
   assign src_addr = idx;

   // Checks placed beside the sequencer they guard.
   assert_erase_opens_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !done) |=> (fl_we && fl_wdata == OP_ERASE_ARM &&
                                     fl_addr == {$past(bank_sel), {OFS_W{1'b0}}}))
      else $error("run does not open with erase arm at bank base");

   assert_poll_read_after_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_POLL_RD) |-> ($past(fl_we) && $past(fl_wdata) == OP_STATUS &&
                                  fl_re && fl_addr == $past(fl_addr)))
      else $error("status read not preceded by status command");

   assert_setup_wait_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_P_DATA) |-> ($past(state_q) == S_P_WAIT &&
                                 $past(wait_cnt) == WCW'(SETUP_WAIT - 1)))
      else $error("data write without full setup wait");

   assert_timeout_at_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_q) |-> ($past(poll_cnt) == PCW'(POLL_LIMIT - 1) && $past(!ready)))
      else $error("timeout before poll limit");

   assert_array_after_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_RST) |-> (fl_wdata == OP_ARRAY && $past(fl_we) &&
                              $past(fl_wdata) == OP_CLR))
      else $error("array-mode write not preceded by clear");

   assert_blank_fault_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q == ERR_BLANK && $past(fault_q) != ERR_BLANK) |->
         ($past(fl_re) && $past(fl_rdata) != ERASED_BYTE))
      else $error("blank fault without a non-blank read");

   assert_compare_fault_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q == ERR_COMPARE && $past(fault_q) != ERR_COMPARE) |->
         ($past(fl_re) && $past(fl_rdata) != $past(src_data)))
      else $error("compare fault without a mismatching read");

   assert_stat_changes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sflag_q != $past(sflag_q)) |->
         ($past(state_q) == S_POLL_RD || $past(state_q) == S_IDLE))
      else $error("status flags changed outside a poll or start");

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle");

   assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy)
      else $error("busy during done");

   assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_we && fl_re))
      else $error("write and read strobes together");

endmodule

// File: tb/fbank_prog_test.sv
module fbank_prog_test;

   localparam int BB = 16;
   localparam int NB = 2;
   localparam int PL = 6;
   localparam int SW = 3;
   localparam int TRN = 2048;

   typedef struct packed {
      logic        bnk;
      logic [15:0] ep;
      logic [15:0] pp;
      logic [2:0]  sb;
      logic [1:0]  st;
      logic [3:0]  sa;
      logic [7:0]  sv;
      logic [7:0]  seed;
      logic [1:0]  xe;
      logic [2:0]  xs;
   } vec_t;

   // bank, erase polls, program polls, status bits, stuck type, stuck addr,
   // stuck value, source seed, expected err_code, expected stat_err
   localparam vec_t VECS [7] = '{
      '{1'b0, 16'd2,   16'd1,   3'd0,   2'd0, 4'd0,  8'h00, 8'h11, 2'd0, 3'd0},
      '{1'b1, 16'd0,   16'd0,   3'd0,   2'd0, 4'd0,  8'h00, 8'h5A, 2'd0, 3'd0},
      '{1'b1, 16'd5,   16'd2,   3'b010, 2'd0, 4'd0,  8'h00, 8'hC3, 2'd0, 3'b010},
      '{1'b0, 16'd6,   16'd0,   3'd0,   2'd0, 4'd0,  8'h00, 8'h21, 2'd1, 3'd0},
      '{1'b0, 16'd0,   16'd100, 3'd0,   2'd0, 4'd0,  8'h00, 8'h42, 2'd1, 3'd0},
      '{1'b1, 16'd1,   16'd0,   3'd0,   2'd1, 4'd7,  8'h00, 8'h77, 2'd2, 3'd0},
      '{1'b0, 16'd0,   16'd1,   3'b101, 2'd2, 4'd15, 8'hA5, 8'h00, 2'd3, 3'b101}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [0:0] bank_sel = 1'b0;
   logic       busy, done;
   logic [1:0] err_code;
   logic [2:0] stat_err;
   logic [3:0] src_addr;
   logic [7:0] src_data;
   logic [4:0] fl_addr;
   logic [7:0] fl_wdata;
   logic       fl_we, fl_re;
   logic [7:0] fl_rdata;

   always #10 clk = ~clk;

   fbank_prog #(.BANK_BYTES(BB), .NUM_BANKS(NB), .POLL_LIMIT(PL), .SETUP_WAIT(SW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .bank_sel(bank_sel),
      .busy(busy), .done(done), .err_code(err_code), .stat_err(stat_err),
      .src_addr(src_addr), .src_data(src_data),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
      .fl_rdata(fl_rdata));

   // Source buffer
   logic [7:0] src_mem [BB];
   assign src_data = src_mem[src_addr];

   // Flash device model configuration
   int         cfg_ep = 0;
   int         cfg_pp = 0;
   logic [2:0] cfg_sb = '0;
   logic [1:0] cfg_st = '0;
   logic [3:0] cfg_sa = '0;
   logic [7:0] cfg_sv = '0;

   logic [7:0] mem [2*BB];
   logic       st_mode;
   logic [1:0] pend;
   int         bpolls;

   always @(posedge clk) begin
      if (!rst_n) begin
         st_mode <= 1'b0;
         pend    <= 2'd0;
         bpolls  <= 0;
         for (int j = 0; j < 2*BB; j++) mem[j] <= 8'(j * 7 + 1);
      end else begin
         if (fl_re && st_mode && bpolls != 0) bpolls <= bpolls - 1;
         if (fl_we) begin
            if (pend == 2'd2) begin
               mem[fl_addr] <= (cfg_st == 2'd2 && fl_addr[3:0] == cfg_sa) ? cfg_sv : fl_wdata;
               bpolls  <= cfg_pp;
               st_mode <= 1'b1;
               pend    <= 2'd0;
            end else if (pend == 2'd1 && fl_wdata == 8'hD0) begin
               for (int j = 0; j < BB; j++)
                  mem[{fl_addr[4], 4'(j)}] <= (cfg_st == 2'd1 && 4'(j) == cfg_sa) ? cfg_sv : 8'hFF;
               bpolls  <= cfg_ep;
               st_mode <= 1'b1;
               pend    <= 2'd0;
            end else begin
               case (fl_wdata)
                  8'h20:   pend <= 2'd1;
                  8'h40:   pend <= 2'd2;
                  8'h70:   begin st_mode <= 1'b1; pend <= 2'd0; end
                  8'hFF:   begin st_mode <= 1'b0; pend <= 2'd0; end
                  default: pend <= 2'd0;
               endcase
            end
         end
      end
   end

   assign fl_rdata = st_mode ? ((bpolls != 0) ? 8'h00 : {2'b10, cfg_sb, 3'b000})
                             : mem[fl_addr];

   // Bus trace and monitors
   logic [4:0] tr_addr [TRN];
   logic [7:0] tr_data [TRN];
   int         tr_cyc  [TRN];
   int         wr_n = 0;
   int         rd_n = 0;
   int         dual_n = 0;
   int         done_n = 0;
   int         cyc = 0;

   int nchk = 0;
   int nerr = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (fl_we) begin
         if (wr_n < TRN) begin
            tr_addr[wr_n] <= fl_addr;
            tr_data[wr_n] <= fl_wdata;
            tr_cyc[wr_n]  <= cyc;
         end
         wr_n <= wr_n + 1;
      end
      if (fl_re) rd_n <= rd_n + 1;
      if (fl_we && fl_re) dual_n <= dual_n + 1;
      if (done) done_n <= done_n + 1;
      if (cyc == 190000) begin
         $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", nchk + 1, nerr + 1);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load_src(input logic [7:0] seed);
      for (int i = 0; i < BB; i++) src_mem[i] = seed ^ 8'(i * 37);
   endtask

   task automatic run_op(input logic b, output logic ok);
      @(negedge clk);
      bank_sel = b;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ok = 1'b0;
      for (int k = 0; k < 4000; k++) begin
         if (done) begin ok = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   function automatic int count_writes(input int from, input int upto,
                                       input logic [7:0] val, input logic [4:0] at);
      int n = 0;
      for (int i = from; i < upto; i++)
         if (tr_data[i] == val && tr_addr[i] == at) n++;
      return n;
   endfunction

   logic [7:0] snap [BB];
   logic       ok;
   int         tb, rb, db;

   initial begin
      for (int i = 0; i < BB; i++) src_mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 busy in reset", busy, 1'b0);
      check("R1 done in reset", done, 1'b0);
      check("R1 err in reset", err_code, 2'd0);
      check("R1 strobes in reset", {fl_we, fl_re}, 2'b00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", {busy, done, fl_we, fl_re}, 4'b0000);

      // Vector table walk
      for (int v = 0; v < 7; v++) begin
         cfg_ep = int'(VECS[v].ep);
         cfg_pp = int'(VECS[v].pp);
         cfg_sb = VECS[v].sb;
         cfg_st = VECS[v].st;
         cfg_sa = VECS[v].sa;
         cfg_sv = VECS[v].sv;
         load_src(VECS[v].seed);
         for (int i = 0; i < BB; i++) snap[i] = mem[{~VECS[v].bnk, 4'(i)}];
         run_op(VECS[v].bnk, ok);
         check("R10 run reaches done", ok, 1'b1);
         // R5 timeout code 1, R7 blank code 2, R8 compare code 3
         check($sformatf("R5/R7/R8 err_code vec %0d", v), err_code, VECS[v].xe);
         check($sformatf("R9 stat_err vec %0d", v), stat_err, VECS[v].xs);
         if (VECS[v].xe == 2'd0) begin
            for (int i = 0; i < BB; i++)
               check($sformatf("R4 programmed byte %0d vec %0d", i, v),
                     mem[{VECS[v].bnk, 4'(i)}], src_mem[i]);
         end
         for (int i = 0; i < BB; i++)
            check($sformatf("R2 other bank byte %0d vec %0d", i, v),
                  mem[{~VECS[v].bnk, 4'(i)}], snap[i]);
         @(negedge clk);
      end

      // Directed: full command trace on bank 1
      cfg_ep = 2; cfg_pp = 1; cfg_sb = 3'd0; cfg_st = 2'd0;
      load_src(8'h3C);
      tb = wr_n;
      run_op(1'b1, ok);
      check("R2 first write is erase arm", {tr_addr[tb], tr_data[tb]}, {5'd16, 8'h20});
      check("R2 second write is erase go", {tr_addr[tb+1], tr_data[tb+1]}, {5'd16, 8'hD0});
      check("R3 poll command at base", {tr_addr[tb+2], tr_data[tb+2]}, {5'd16, 8'h70});
      check("R3 status command count", count_writes(tb, wr_n, 8'h70, 5'd16), 32'd35);
      check("R6 clear after erase", {tr_addr[tb+5], tr_data[tb+5]}, {5'd16, 8'h50});
      check("R6 array mode after erase", {tr_addr[tb+6], tr_data[tb+6]}, {5'd16, 8'hFF});
      check("R4 arm byte 0", {tr_addr[tb+7], tr_data[tb+7]}, {5'd16, 8'h40});
      check("R4 data byte 0", {tr_addr[tb+8], tr_data[tb+8]}, {5'd16, src_mem[0]});
      check("R4 setup wait span", tr_cyc[tb+8] - tr_cyc[tb+7], SW + 1);
      check("R4 arm byte 5", {tr_addr[tb+27], tr_data[tb+27]}, {5'd21, 8'h40});
      check("R4 data byte 5", {tr_addr[tb+28], tr_data[tb+28]}, {5'd21, src_mem[5]});
      check("R6 clear after program", {tr_addr[tb+71], tr_data[tb+71]}, {5'd16, 8'h50});
      check("R6 array mode after program", {tr_addr[tb+72], tr_data[tb+72]}, {5'd16, 8'hFF});
      check("R8 trace run passes", err_code, 2'd0);
      check("R6 total writes", wr_n - tb, 32'd73);
      @(negedge clk);

      // Directed: erase timeout skips verify and programming
      cfg_ep = 1000; cfg_pp = 0;
      tb = wr_n; rb = rd_n;
      run_op(1'b0, ok);
      check("R5 erase timeout code", err_code, 2'd1);
      check("R5 polls before timeout", count_writes(tb, wr_n, 8'h70, 5'd0), PL);
      check("R5 no verify reads", rd_n - rb, PL);
      check("R6 clear after timeout", tr_data[wr_n-2], 8'h50);
      check("R6 array mode after timeout", tr_data[wr_n-1], 8'hFF);
      check("R5 timeout total writes", wr_n - tb, 32'd10);
      @(negedge clk);

      // Directed: program timeout aborts remaining bytes
      cfg_ep = 0; cfg_pp = 1000;
      tb = wr_n;
      run_op(1'b0, ok);
      check("R5 program timeout code", err_code, 2'd1);
      check("R5 only first byte armed", count_writes(tb, wr_n, 8'h40, 5'd0), 32'd1);
      check("R5 no arm of byte 1", count_writes(tb, wr_n, 8'h40, 5'd1), 32'd0);
      @(negedge clk);

      // Directed: start while busy is ignored
      cfg_ep = 0; cfg_pp = 0;
      load_src(8'h99);
      for (int i = 0; i < BB; i++) snap[i] = mem[{1'b1, 4'(i)}];
      db = done_n;
      @(negedge clk);
      bank_sel = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R10 busy after start", busy, 1'b1);
      repeat (5) @(negedge clk);
      bank_sel = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 4000 && !done; k++) @(negedge clk);
      check("R10 done with busy low", {done, busy}, 2'b10);
      @(negedge clk);
      check("R10 done one cycle", done, 1'b0);
      repeat (4) @(negedge clk);
      check("R10 one run only", done_n - db, 32'd1);
      check("R10 idle after run", busy, 1'b0);
      for (int i = 0; i < BB; i++)
         check($sformatf("R10 ignored start left bank1 byte %0d", i),
               mem[{1'b1, 4'(i)}], snap[i]);

      // Directed: reset in the middle of a run
      @(negedge clk);
      bank_sel = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset aborts run", {busy, done, fl_we, fl_re}, 4'b0000);
      check("R1 reset clears err", err_code, 2'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 stays idle after reset", busy, 1'b0);

      check("R11 strobes never overlap", dual_n, 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule